// File: doc/BRIEF.md
# Display Function Configuration Responder

This block answers byte-wide configuration reads and writes for a display function that sits on a PCI-style bus as a type-0 device. Its fixed identification bytes are set by parameters. It also holds a small set of writable fields: a command byte, the top byte of a linear framebuffer base, an expansion-ROM base with its enable bit, and an interrupt-line byte.

From the stored fields it produces the decode enables that the address decoders elsewhere use. There are two I/O port range enables, an enable for the legacy memory window, an enable and base for a 16 MB linear framebuffer window, an enable for a fixed alias of that window, and an enable and base for a 64 KB ROM window. Bus protocol timing is not handled here. The caller presents a function number, a byte offset, write data and a write strobe, and receives the read byte.

Top module: `dcfg_space`

## Requirements
- R1: For function 0, offsets 0x00..0x03 read 0x34, 0x12, 0x11, 0x11; offset 0x06 reads 0x80, 0x07 reads 0x02, 0x0B reads 0x03 and 0x3D reads 0x01. Writes to these offsets change nothing.
- R2: For any function other than 0, every offset reads 0xFF and writes change no state or output.
- R3: A write to offset 0x04 stores the command byte. Reading offset 0x04 returns (stored AND 0xE3) OR 0x80.
- R4: Both I/O enables (`io_vga_en` for ports 0x3C0..0x3DF, `io_ext_en` for ports 0x1CE..0x1D0) equal command bit 0.
- R5: `legacy_mem_en` equals command bit 1.
- R6: Offset 0x13 is the read/write framebuffer base byte, and `lfb_base` is that byte shifted left by 24. Offset 0x17 reads 0xE0 while the byte is non-zero and 0x00 otherwise.
- R7: `lfb_en` is 1 exactly when command bit 1 is set and the base byte is non-zero.
- R8: `alias_en` (a 16 MB alias at 0xE0000000) is 1 exactly when `lfb_en` is 1 and the base byte is not 0xE0.
- R9: Offset 0x30 stores only bit 0 as the ROM enable and reads back as that bit. `rom_en` follows it.
- R10: Offset 0x32 stores its data AND 0xFC, and offset 0x33 stores its full data. Both read back as stored. `rom_base` is {byte 0x33, byte 0x32} shifted left by 16.
- R11: Offset 0x3C is a read/write interrupt-line byte.
- R12: All other offsets of function 0 read 0x00, and writes to them change nothing.
- R13: After reset all writable fields are 0, so every enable output is 0.
- R14: A write takes effect at the clock edge that samples it. Read data is combinational from the current offset and state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Function number |
| cfg_addr | input | 8 | Byte offset in configuration space |
| cfg_wr | input | 1 | Write strobe, sampled on the rising edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data |
| io_vga_en | output | 1 | Decode enable for ports 0x3C0..0x3DF |
| io_ext_en | output | 1 | Decode enable for ports 0x1CE..0x1D0 |
| legacy_mem_en | output | 1 | Decode enable for the legacy memory window |
| lfb_en | output | 1 | Linear framebuffer window enable |
| lfb_base | output | 32 | Linear framebuffer window base address |
| alias_en | output | 1 | Fixed alias window enable |
| rom_en | output | 1 | ROM window enable |
| rom_base | output | 32 | ROM window base address |

## Verification
Read data has no register on its path. The bench therefore drives the offset on a falling edge and samples `cfg_rdata` one nanosecond later, within the same cycle. A write is captured on the next rising edge, and all decode outputs are pure logic from the stored fields. The bench drops the strobe on the following falling edge and checks every output there, which is one cycle after the write was presented. Random writes and reads go to function 0 and to other functions. They are compared with a bench model, and directed cases cover the base byte at 0x00 and 0xE0, the masked ROM low byte and the command mask.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

   localparam logic [7:0] OFS_CMD     = 8'h04;
   localparam logic [7:0] OFS_FB_HI   = 8'h13;
   localparam logic [7:0] OFS_FB_FLAG = 8'h17;
   localparam logic [7:0] OFS_ROM_CTL = 8'h30;
   localparam logic [7:0] OFS_ROM_LO  = 8'h32;
   localparam logic [7:0] OFS_ROM_HI  = 8'h33;
   localparam logic [7:0] OFS_IRQ_LN  = 8'h3C;
   localparam logic [7:0] OFS_IRQ_PIN = 8'h3D;

   localparam int CMD_IO_BIT  = 0;
   localparam int CMD_MEM_BIT = 1;

   localparam logic [7:0] CMD_KEEP  = 8'hE3;
   localparam logic [7:0] CMD_FORCE = 8'h80;
   localparam logic [7:0] ROM_LO_KEEP = 8'hFC;

   typedef struct packed {
      logic [7:0] cmd;
      logic [7:0] fb_hi;
      logic [7:0] rom_lo;
      logic [7:0] rom_hi;
      logic [7:0] irq_line;
      logic       rom_on;
   } dcfg_state_t;

endpackage

// File: rtl/dcfg_regs.sv
module dcfg_regs
   import dcfg_pkg::*;
#(
   parameter int FUNC_W = 3,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] func,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [7:0]        wdata,
   output dcfg_state_t       st
);

   logic own_fn;
   logic wr_ok;
   assign own_fn = (func == '0);
   assign wr_ok  = wr && own_fn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else if (wr_ok) begin
         case (addr)
            ADDR_W'(OFS_CMD):     st.cmd      <= wdata;
            ADDR_W'(OFS_FB_HI):   st.fb_hi    <= wdata;
            ADDR_W'(OFS_ROM_CTL): st.rom_on   <= wdata[0];
            ADDR_W'(OFS_ROM_LO):  st.rom_lo   <= wdata & ROM_LO_KEEP;
            ADDR_W'(OFS_ROM_HI):  st.rom_hi   <= wdata;
            ADDR_W'(OFS_IRQ_LN):  st.irq_line <= wdata;
            default: ;
         endcase
      end
   end

   // R11: interrupt line holds the written byte
   assert_irq_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && own_fn && addr == ADDR_W'(OFS_IRQ_LN)) |=> (st.irq_line == $past(wdata)));

   // R2: writes aimed at another function leave state untouched
   assert_other_fn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !own_fn) |=> $stable(st));

   // R10: low ROM base byte never carries its two low bits
   assert_rom_lo_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st.rom_lo[1:0] == 2'b00);

endmodule

// File: rtl/dcfg_readmux.sv
module dcfg_readmux
   import dcfg_pkg::*;
#(
   parameter int         FUNC_W   = 3,
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] ID_B0    = 8'h34,
   parameter logic [7:0] ID_B1    = 8'h12,
   parameter logic [7:0] ID_B2    = 8'h11,
   parameter logic [7:0] ID_B3    = 8'h11,
   parameter logic [7:0] STAT_LO  = 8'h80,
   parameter logic [7:0] STAT_HI  = 8'h02,
   parameter logic [7:0] CLASS_B  = 8'h03,
   parameter logic [7:0] PIN_B    = 8'h01,
   parameter logic [7:0] FB_FLAG  = 8'hE0
) (
   input  logic [FUNC_W-1:0] func,
   input  logic [ADDR_W-1:0] addr,
   input  dcfg_state_t       st,
   output logic [7:0]        rdata
);

   localparam int NUM_ID = 4;
   localparam logic [NUM_ID*8-1:0] ID_VEC = {ID_B3, ID_B2, ID_B1, ID_B0};

   logic [7:0] id_sel [NUM_ID];
   logic [NUM_ID-1:0] id_hit;

   for (genvar i = 0; i < NUM_ID; i++) begin : g_id
      assign id_sel[i] = ID_VEC[i*8 +: 8];
      assign id_hit[i] = (addr == ADDR_W'(i));
   end

   logic [7:0] own_data;

   always_comb begin
      own_data = 8'h00;
      for (int i = 0; i < NUM_ID; i++) begin
         if (id_hit[i]) own_data = id_sel[i];
      end
      case (addr)
         ADDR_W'(OFS_CMD):     own_data = (st.cmd & CMD_KEEP) | CMD_FORCE;
         ADDR_W'(8'h06):       own_data = STAT_LO;
         ADDR_W'(8'h07):       own_data = STAT_HI;
         ADDR_W'(8'h0B):       own_data = CLASS_B;
         ADDR_W'(OFS_FB_HI):   own_data = st.fb_hi;
         ADDR_W'(OFS_FB_FLAG): own_data = (st.fb_hi != 8'h00) ? FB_FLAG : 8'h00;
         ADDR_W'(OFS_ROM_CTL): own_data = {7'd0, st.rom_on};
         ADDR_W'(OFS_ROM_LO):  own_data = st.rom_lo;
         ADDR_W'(OFS_ROM_HI):  own_data = st.rom_hi;
         ADDR_W'(OFS_IRQ_LN):  own_data = st.irq_line;
         ADDR_W'(OFS_IRQ_PIN): own_data = PIN_B;
         default: ;
      endcase
   end

   assign rdata = (func == '0) ? own_data : 8'hFF;

   // R1/R3: command readback always has its top bit forced
   always_comb begin
      if (func == '0 && addr == ADDR_W'(OFS_CMD))
         assert_cmd_force_R3: assert (rdata[7] == 1'b1);
   end

endmodule

// File: rtl/dcfg_decode.sv
module dcfg_decode
   import dcfg_pkg::*;
#(
   parameter int         AW         = 32,
   parameter int         LFB_SHIFT  = 24,
   parameter int         ROM_SHIFT  = 16,
   parameter logic [7:0] ALIAS_BYTE = 8'hE0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  dcfg_state_t   st,
   output logic          io_vga_en,
   output logic          io_ext_en,
   output logic          legacy_mem_en,
   output logic          lfb_en,
   output logic [AW-1:0] lfb_base,
   output logic          alias_en,
   output logic          rom_en,
   output logic [AW-1:0] rom_base
);

   localparam int LFB_TOP = LFB_SHIFT + 8;
   localparam int ROM_TOP = ROM_SHIFT + 16;

   if (LFB_TOP > AW) begin : g_bad_lfb
      $error("dcfg_decode: framebuffer base does not fit the address width");
   end
   if (ROM_TOP > AW) begin : g_bad_rom
      $error("dcfg_decode: ROM base does not fit the address width");
   end

   logic io_on, mem_on, fb_set;
   assign io_on  = st.cmd[CMD_IO_BIT];
   assign mem_on = st.cmd[CMD_MEM_BIT];
   assign fb_set = (st.fb_hi != 8'h00);

   assign io_vga_en     = io_on;
   assign io_ext_en     = io_on;
   assign legacy_mem_en = mem_on;
   assign lfb_en        = mem_on && fb_set;
   assign alias_en      = lfb_en && (st.fb_hi != ALIAS_BYTE);
   assign rom_en        = st.rom_on;

   assign lfb_base = AW'(st.fb_hi) << LFB_SHIFT;
   assign rom_base = AW'({st.rom_hi, st.rom_lo}) << ROM_SHIFT;

   assert_alias_needs_lfb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alias_en |-> lfb_en);

   assert_lfb_needs_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lfb_en |-> (legacy_mem_en && lfb_base != '0));

   assert_io_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      io_vga_en == io_ext_en);

   assert_rom_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rom_base[ROM_SHIFT+1 -: 2] == 2'b00);

endmodule

// File: rtl/dcfg_space.sv
module dcfg_space
   import dcfg_pkg::*;
#(
   parameter int FUNC_W   = 3,
   parameter int ADDR_W   = 8,
   parameter int AW       = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] cfg_func,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              io_vga_en,
   output logic              io_ext_en,
   output logic              legacy_mem_en,
   output logic              lfb_en,
   output logic [AW-1:0]     lfb_base,
   output logic              alias_en,
   output logic              rom_en,
   output logic [AW-1:0]     rom_base
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("dcfg_space: offset width must cover 256 bytes");
   end
   if (FUNC_W < 1) begin : g_bad_func
      $error("dcfg_space: function field must be at least one bit");
   end

   dcfg_state_t st;
   logic [7:0]  rd_comb;

   dcfg_regs #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .func  (cfg_func),
      .addr  (cfg_addr),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .st    (st)
   );

   dcfg_readmux #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W)) u_rd (
      .func  (cfg_func),
      .addr  (cfg_addr),
      .st    (st),
      .rdata (rd_comb)
   );

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) cfg_rdata <= 8'h00;
         else        cfg_rdata <= rd_comb;
      end
   end else begin : g_rd_comb
      assign cfg_rdata = rd_comb;
   end

   dcfg_decode #(.AW(AW)) u_dec (
      .clk           (clk),
      .rst_n         (rst_n),
      .st            (st),
      .io_vga_en     (io_vga_en),
      .io_ext_en     (io_ext_en),
      .legacy_mem_en (legacy_mem_en),
      .lfb_en        (lfb_en),
      .lfb_base      (lfb_base),
      .alias_en      (alias_en),
      .rom_en        (rom_en),
      .rom_base      (rom_base)
   );

   // R2: foreign function reads all ones
   assert_foreign_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_func != '0) |-> (rd_comb == 8'hFF));

endmodule

// File: tb/dcfg_space_tb.sv
module dcfg_space_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_func = '0;
   logic [7:0]  cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        io_vga_en, io_ext_en, legacy_mem_en, lfb_en, alias_en, rom_en;
   logic [31:0] lfb_base, rom_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0] m_cmd, m_fb, m_rlo, m_rhi, m_irq;
   logic       m_ron;

   always #5 clk = ~clk;

   dcfg_space u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .io_vga_en(io_vga_en), .io_ext_en(io_ext_en), .legacy_mem_en(legacy_mem_en),
      .lfb_en(lfb_en), .lfb_base(lfb_base), .alias_en(alias_en),
      .rom_en(rom_en), .rom_base(rom_base)
   );

   function automatic logic [7:0] exp_rd(input logic [2:0] f, input logic [7:0] a);
      if (f != 0) return 8'hFF;
      case (a)
         8'h00: return 8'h34;
         8'h01: return 8'h12;
         8'h02: return 8'h11;
         8'h03: return 8'h11;
         8'h04: return (m_cmd & 8'hE3) | 8'h80;
         8'h06: return 8'h80;
         8'h07: return 8'h02;
         8'h0B: return 8'h03;
         8'h13: return m_fb;
         8'h17: return (m_fb != 0) ? 8'hE0 : 8'h00;
         8'h30: return {7'd0, m_ron};
         8'h32: return m_rlo;
         8'h33: return m_rhi;
         8'h3C: return m_irq;
         8'h3D: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] f, input logic [7:0] a);
      if (f != 0) return "R2";
      case (a)
         8'h00, 8'h01, 8'h02, 8'h03, 8'h06, 8'h07, 8'h0B, 8'h3D: return "R1";
         8'h04: return "R3";
         8'h13, 8'h17: return "R6";
         8'h30: return "R9";
         8'h32, 8'h33: return "R10";
         8'h3C: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
      if (f != 0) return;
      case (a)
         8'h04: m_cmd = d;
         8'h13: m_fb  = d;
         8'h30: m_ron = d[0];
         8'h32: m_rlo = d & 8'hFC;
         8'h33: m_rhi = d;
         8'h3C: m_irq = d;
         default: ;
      endcase
   endtask

   // outputs are checked one falling edge after the write strobe, i.e. after the capturing edge
   task automatic chk_outs(input string tag);
      logic lfb_x;
      lfb_x = m_cmd[1] && (m_fb != 0);
      chk("R4",  {tag, " io_vga_en"}, io_vga_en, m_cmd[0]);
      chk("R4",  {tag, " io_ext_en"}, io_ext_en, m_cmd[0]);
      chk("R5",  {tag, " legacy_mem_en"}, legacy_mem_en, m_cmd[1]);
      chk("R7",  {tag, " lfb_en"}, lfb_en, lfb_x);
      chk("R6",  {tag, " lfb_base"}, lfb_base, {m_fb, 24'h0});
      chk("R8",  {tag, " alias_en"}, alias_en, lfb_x && (m_fb != 8'hE0));
      chk("R9",  {tag, " rom_en"}, rom_en, m_ron);
      chk("R10", {tag, " rom_base"}, rom_base, {m_rhi, m_rlo, 16'h0});
   endtask

   task automatic do_wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      model_wr(f, a, d);
      chk_outs("R14 after write");
   endtask

   task automatic do_rd(input logic [2:0] f, input logic [7:0] a);
      @(negedge clk);
      cfg_func = f; cfg_addr = a; cfg_wr = 1'b0;
      #1;
      chk(req_of(f, a), $sformatf("read f%0d @%02h", f, a), cfg_rdata, exp_rd(f, a));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] hot [10];
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      hot = '{8'h04, 8'h13, 8'h17, 8'h30, 8'h32, 8'h33, 8'h3C, 8'h00, 8'h3D, 8'h20};
      m_cmd = 0; m_fb = 0; m_rlo = 0; m_rhi = 0; m_irq = 0; m_ron = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: everything off after reset
      chk_outs("R13 reset");
      do_rd(0, 8'h04);
      for (int a = 0; a < 8'h40; a++) do_rd(0, 8'(a));

      // directed corners
      do_wr(0, 8'h04, 8'hFF); do_rd(0, 8'h04);           // R3 mask
      do_wr(0, 8'h13, 8'hE0); do_rd(0, 8'h17);           // R8 no alias at E0
      chk("R8", "alias off at E0", alias_en, 1'b0);
      do_wr(0, 8'h13, 8'hC0);                            // R8 alias on
      chk("R8", "alias on at C0", alias_en, 1'b1);
      do_wr(0, 8'h13, 8'h00); do_rd(0, 8'h17);           // R6/R7 zero base
      do_wr(0, 8'h32, 8'hFF); do_rd(0, 8'h32);           // R10 masked
      do_wr(0, 8'h33, 8'hAB); do_wr(0, 8'h30, 8'hFE);    // R9 bit 0 only
      do_rd(0, 8'h30);
      do_wr(0, 8'h30, 8'h01);
      do_wr(0, 8'h00, 8'h55); do_rd(0, 8'h00);           // R1 read-only
      do_wr(0, 8'h20, 8'h77); do_rd(0, 8'h20);           // R12 ignored
      do_wr(3, 8'h04, 8'h00); do_rd(3, 8'h04);           // R2 ignored
      do_wr(0, 8'h3C, 8'h0B); do_rd(0, 8'h3C);           // R11

      for (int i = 0; i < 600; i++) begin
         logic [2:0] f;
         logic [7:0] a;
         f = ($urandom % 5 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
         a = ($urandom % 4 == 0) ? 8'($urandom) : hot[$urandom % 10];
         if ($urandom % 2) do_wr(f, a, 8'($urandom));
         else              do_rd(f, a);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule